// File: doc/BRIEF.md
# Open-Drain Keypad Matrix Scanner

This block scans a 3-column by 4-row telephone keypad that has no isolation diodes. It drives one column at a time. The selected column is pulled low through an open-drain enable, and the other two columns are left floating. The rows carry external pull-ups, so a closed key on the driven column reads as a low row. Because no column is ever driven high, two keys closed in one row cannot short a high-driven column against a low-driven one. Without that short, the row pattern stays true.

Each row passes through a two-flop synchroniser. A scan-tick divider sets the pace. After every column change, one tick is allowed for settling before the rows are sampled. A press must stay unchanged for a set number of ticks before it is accepted. The accepted key appears as a 4-bit code with a one-cycle strobe.

While a key is held, the scan stays on its column, so the first key found wins and later keys are not seen. Scanning moves on only after every row has read released for the same number of ticks.

Top module: `kpad_scan`

## Requirements
- R1: During and right after reset, `col_oe` is 3'b001 (column 0 driven), `key_valid` is 0 and `key_code` is 0.
- R2: Exactly one bit of `col_oe` is high at any time; bit c high means column c is pulled low, and no output ever drives a column high. The driven column steps 0, 1, 2, 0, so bit0 moves to bit1, then bit2, then back to bit0.
- R3: `row_n[r]` low means a closed key at row r on the driven column. Row 0 is the top row and column 0 is the left column. Rows 0 to 2 give code 3*r + c + 1. In row 3, column 0 gives 10 (star), column 1 gives 0 and column 2 gives 11 (hash).
- R4: Each accepted press gives exactly one `key_valid` pulse, one clock long, however long the key stays held.
- R5: A press is accepted only after the row pattern seen at detection has stayed unchanged for DEB_TICKS further ticks. A closure lasting two ticks or less produces no `key_valid`.
- R6: While an accepted key is held, `col_oe` does not change. Keys closed later in other columns, including keys in the same row, produce no `key_valid`.
- R7: The scan leaves a column only when all rows read high. After an accepted press, it leaves only after all rows have read high for DEB_TICKS ticks. A shorter release followed by a re-press gives no new pulse. After a full release, a key that is still held on another column is reported.
- R8: If several rows read low on the driven column when a press is detected, the lowest row index is reported.
- R9: With no key closed, each column stays driven for exactly 2*TICK_DIV clocks: one settling tick, then one sampling tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_n | input | 4 | Row sense lines, externally pulled up; low = closed key on the driven column |
| col_oe | output | 3 | Per-column enable of a low-only driver; 0 leaves the column floating |
| key_code | output | 4 | Code of the last accepted key |
| key_valid | output | 1 | One-clock strobe for each accepted press |

## Verification
The bench models the matrix arithmetically: a row reads low only when a closed key sits on the column whose enable is high. It sweeps all twelve keys, holding each well past acceptance, which separates wrong code mapping from repeated strobes.

Two-key patterns cover four cases:
- two rows in one column, which shows whether the lowest row is picked;
- a held key with a same-row key tapped repeatedly, which shows whether the scan stays parked;
- keys in two columns pressed in sequence, which shows whether the first key wins and the second is reported after release;
- a brief release and a brief glitch, which show whether both directions of debounce work.

With idle keys, the bench times the column dwell and the rotation order.

// File: rtl/kpad_pkg.sv
package kpad_pkg;

    localparam int KP_NCOL   = 3;
    localparam int KP_NROW   = 4;
    localparam int KP_CODE_W = 4;

    typedef enum logic [2:0] {
        ST_SETTLE   = 3'd0,
        ST_SAMPLE   = 3'd1,
        ST_PRESS_DB = 3'd2,
        ST_HELD     = 3'd3,
        ST_REL_DB   = 3'd4
    } kp_state_e;

    // Telephone layout: digits on the upper rows, star/zero/hash on the last row.
    function automatic logic [KP_CODE_W-1:0] kp_key_code(input int unsigned row,
                                                          input int unsigned col);
        logic [KP_CODE_W-1:0] code;
        if (row < KP_NROW - 1) begin
            code = KP_CODE_W'(row * KP_NCOL + col + 1);
        end else begin
            case (col)
                0:       code = KP_CODE_W'(10);
                1:       code = KP_CODE_W'(0);
                default: code = KP_CODE_W'(11);
            endcase
        end
        return code;
    endfunction

endpackage

// File: rtl/kpad_sync.sv
module kpad_sync #(
    parameter int   W       = 4,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= {W{RST_VAL}};
            sync_q <= {W{RST_VAL}};
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;

endmodule

// File: rtl/kpad_tick.sv
module kpad_tick #(
    parameter int DIV = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int TW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [TW-1:0] cnt_d, cnt_q;
    logic          tick_d, tick_q;

    always_comb begin
        if (cnt_q == TW'(DIV - 1)) begin
            cnt_d  = '0;
            tick_d = 1'b1;
        end else begin
            cnt_d  = cnt_q + TW'(1);
            tick_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            tick_q <= tick_d;
        end
    end

    assign tick = tick_q;

endmodule

// File: rtl/kpad_row_pick.sv
module kpad_row_pick #(
    parameter int NROW = 4,
    parameter int RW   = 2
) (
    input  logic [NROW-1:0] act,
    output logic [RW-1:0]   idx
);

    // Walk from the top index down so the lowest active row is the final choice.
    always_comb begin
        idx = '0;
        for (int r = NROW - 1; r >= 0; r--) begin
            if (act[r]) idx = RW'(r);
        end
    end

endmodule

// File: rtl/kpad_scan.sv
module kpad_scan
    import kpad_pkg::*;
#(
    parameter int TICK_DIV  = 100000,
    parameter int DEB_TICKS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [KP_NROW-1:0]   row_n,
    output logic [KP_NCOL-1:0]   col_oe,
    output logic [KP_CODE_W-1:0] key_code,
    output logic                 key_valid
);

    localparam int CW = $clog2(KP_NCOL);
    localparam int RW = $clog2(KP_NROW);
    localparam int DW = $clog2(DEB_TICKS + 1);

    typedef struct packed {
        kp_state_e            state;
        logic [CW-1:0]        col;
        logic [KP_NROW-1:0]   pat;
        logic [DW-1:0]        cnt;
        logic                 valid;
        logic [KP_CODE_W-1:0] code;
    } scan_t;

    scan_t s_d, s_q;

    logic                tick;
    logic [KP_NROW-1:0]  rows_s;
    logic [KP_NROW-1:0]  hit;
    logic                any_hit;
    logic [RW-1:0]       pick_row;
    logic [CW-1:0]       next_col;

    kpad_sync #(.W(KP_NROW), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (row_n),
        .dout (rows_s)
    );

    kpad_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    kpad_row_pick #(.NROW(KP_NROW), .RW(RW)) u_pick (
        .act(s_q.pat),
        .idx(pick_row)
    );

    assign hit      = ~rows_s;
    assign any_hit  = |hit;
    assign next_col = (s_q.col == CW'(KP_NCOL - 1)) ? '0 : s_q.col + CW'(1);

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        if (tick) begin
            unique case (s_q.state)
                ST_SETTLE: begin
                    s_d.state = ST_SAMPLE;
                end
                ST_SAMPLE: begin
                    if (any_hit) begin
                        s_d.pat   = hit;
                        s_d.cnt   = '0;
                        s_d.state = ST_PRESS_DB;
                    end else begin
                        s_d.col   = next_col;
                        s_d.state = ST_SETTLE;
                    end
                end
                ST_PRESS_DB: begin
                    if (!any_hit) begin
                        s_d.cnt   = '0;
                        s_d.state = ST_SAMPLE;
                    end else if (hit != s_q.pat) begin
                        s_d.pat = hit;
                        s_d.cnt = '0;
                    end else if (s_q.cnt == DW'(DEB_TICKS - 1)) begin
                        s_d.valid = 1'b1;
                        s_d.code  = kp_key_code(int'(pick_row), int'(s_q.col));
                        s_d.cnt   = '0;
                        s_d.state = ST_HELD;
                    end else begin
                        s_d.cnt = s_q.cnt + DW'(1);
                    end
                end
                ST_HELD: begin
                    if (!any_hit) begin
                        s_d.cnt   = '0;
                        s_d.state = ST_REL_DB;
                    end
                end
                ST_REL_DB: begin
                    if (any_hit) begin
                        s_d.cnt   = '0;
                        s_d.state = ST_HELD;
                    end else if (s_q.cnt == DW'(DEB_TICKS - 1)) begin
                        s_d.cnt   = '0;
                        s_d.col   = next_col;
                        s_d.state = ST_SETTLE;
                    end else begin
                        s_d.cnt = s_q.cnt + DW'(1);
                    end
                end
                default: begin
                    s_d.state = ST_SETTLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // One enable per column; an enabled column is only ever pulled low.
    for (genvar c = 0; c < KP_NCOL; c++) begin : g_col
        assign col_oe[c] = (s_q.col == CW'(c));
    end

    assign key_valid = s_q.valid;
    assign key_code  = s_q.code;

endmodule

// File: rtl/kpad_scan_chk.sv
module kpad_scan_chk
    import kpad_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [KP_NCOL-1:0]   col_oe,
    input logic [KP_NROW-1:0]   rows_s,
    input logic                 key_valid,
    input logic [KP_CODE_W-1:0] key_code
);

    function automatic logic [KP_NCOL-1:0] rotl(input logic [KP_NCOL-1:0] v);
        return {v[KP_NCOL-2:0], v[KP_NCOL-1]};
    endfunction

    assert_one_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(col_oe));

    assert_col_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(col_oe) |-> col_oe == rotl($past(col_oe)));

    assert_leave_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(col_oe) |-> (&$past(rows_s)));

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> !key_valid);

    assert_code_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> key_code <= KP_CODE_W'(11));

endmodule

bind kpad_scan kpad_scan_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .col_oe   (col_oe),
    .rows_s   (rows_s),
    .key_valid(key_valid),
    .key_code (key_code)
);

// File: tb/sim_kpad_scan.sv
`timescale 1ns/1ps
module sim_kpad_scan;
    import kpad_pkg::*;

    localparam int TICK = 4;
    localparam int DEB  = 4;
    localparam int NK   = KP_NROW * KP_NCOL;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [KP_NROW-1:0]   row_n;
    logic [KP_NCOL-1:0]   col_oe;
    logic [KP_CODE_W-1:0] key_code;
    logic                 key_valid;
    logic [NK-1:0]        keys;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    int last_code = -1;

    always #5 clk = ~clk;

    kpad_scan #(.TICK_DIV(TICK), .DEB_TICKS(DEB)) u0 (
        .clk(clk), .rst_n(rst_n), .row_n(row_n),
        .col_oe(col_oe), .key_code(key_code), .key_valid(key_valid)
    );

    // Matrix model: key k = r*3 + c; a row reads low through a closed key on an enabled column.
    for (genvar r = 0; r < KP_NROW; r++) begin : g_row
        assign row_n[r] = ~|(keys[r*KP_NCOL +: KP_NCOL] & col_oe);
    end

    always @(negedge clk) begin
        if (rst_n && key_valid) begin
            pulses++;
            last_code = int'(key_code);
        end
    end

    function automatic int exp_code(input int k);
        int r = k / KP_NCOL;
        int c = k % KP_NCOL;
        if (r < KP_NROW - 1) return k + 1;
        return (c == 0) ? 10 : (c == 1) ? 0 : 11;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_pulse(input int target, input int maxc);
        for (int i = 0; i < maxc && pulses < target; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int base;
        logic [KP_NCOL-1:0] prev;
        int dwell;
        keys  = '0;
        rst_n = 1'b0;
        wcyc(5);
        chk(col_oe == 3'b001, "R1 col_oe in reset", col_oe, 1);
        chk(key_valid == 1'b0, "R1 key_valid in reset", key_valid, 0);
        chk(key_code == '0, "R1 key_code in reset", key_code, 0);
        rst_n = 1'b1;
        wcyc(1);
        chk(col_oe == 3'b001, "R1 col_oe after reset", col_oe, 1);

        // R2 / R9: rotation order and dwell with idle keys
        for (int t = 0; t < 4; t++) begin
            prev = col_oe;
            for (int i = 0; i < 50 && col_oe == prev; i++) @(negedge clk);
            chk(col_oe == (((prev << 1) | (prev >> (KP_NCOL - 1))) & 3'b111),
                "R2 rotation", col_oe, ((prev << 1) | (prev >> 2)) & 7);
            if (t > 0) begin
                prev  = col_oe;
                dwell = 0;
                while (col_oe == prev && dwell < 50) begin
                    @(negedge clk);
                    dwell++;
                end
                chk(dwell == 2 * TICK, "R9 dwell", dwell, 2 * TICK);
            end
        end

        // R3 / R4: sweep every key
        for (int k = 0; k < NK; k++) begin
            base = pulses;
            keys[k] = 1'b1;
            wait_pulse(base + 1, 400);
            chk(pulses == base + 1, "R3 press seen", pulses - base, 1);
            chk(last_code == exp_code(k), "R3 code", last_code, exp_code(k));
            wcyc(200);
            chk(pulses == base + 1, "R4 one pulse while held", pulses - base, 1);
            keys[k] = 1'b0;
            wcyc(150);
        end

        // R5: short glitch on the driven column is rejected
        for (int i = 0; i < 50 && col_oe != 3'b010; i++) @(negedge clk);
        base = pulses;
        keys[4] = 1'b1;
        wcyc(8);
        keys[4] = 1'b0;
        wcyc(300);
        chk(pulses == base, "R5 glitch rejected", pulses - base, 0);

        // R8: two rows of one column closed together -> lowest row
        base = pulses;
        keys[1] = 1'b1;
        keys[7] = 1'b1;
        wait_pulse(base + 1, 400);
        chk(last_code == 2, "R8 lowest row wins", last_code, 2);
        keys[1] = 1'b0;
        keys[7] = 1'b0;
        wcyc(150);

        // R6: hold key 6, tap key 4 in the same row
        base = pulses;
        keys[5] = 1'b1;
        wait_pulse(base + 1, 400);
        chk(last_code == 6, "R6 held key code", last_code, 6);
        for (int t = 0; t < 5; t++) begin
            keys[3] = 1'b1;
            wcyc(30);
            keys[3] = 1'b0;
            wcyc(30);
        end
        chk(pulses == base + 1, "R6 taps ignored", pulses - base, 1);
        chk(col_oe == 3'b100, "R6 column parked", col_oe, 4);
        keys[5] = 1'b0;
        wcyc(150);
        chk(pulses == base + 1, "R6 no pulse on release", pulses - base, 1);
        keys[3] = 1'b1;
        wait_pulse(base + 2, 400);
        chk(last_code == 4, "R7 scan resumes", last_code, 4);
        keys[3] = 1'b0;
        wcyc(150);

        // R6 / R7: key 3 first, then 7; 7 reported after 3 released
        base = pulses;
        keys[2] = 1'b1;
        wait_pulse(base + 1, 400);
        chk(last_code == 3, "R6 first key", last_code, 3);
        keys[6] = 1'b1;
        wcyc(200);
        chk(pulses == base + 1, "R6 second key ignored", pulses - base, 1);
        keys[2] = 1'b0;
        wait_pulse(base + 2, 400);
        chk(last_code == 7, "R7 held key after release", last_code, 7);
        keys[6] = 1'b0;
        wcyc(150);

        // R7: short release is not a release
        base = pulses;
        keys[4] = 1'b1;
        wait_pulse(base + 1, 400);
        wcyc(50);
        keys[4] = 1'b0;
        wcyc(6);
        keys[4] = 1'b1;
        wcyc(200);
        chk(pulses == base + 1, "R7 short release", pulses - base, 1);
        keys[4] = 1'b0;
        wcyc(150);

        finish_run();
    end

endmodule